// File: doc/BRIEF.md
# Frame-Locked Output Timing Sequencer

This block produces the pixel and line counters that pace a display panel. It locks the output frame to a vertical-enable trigger that comes from the input video. Left alone, it runs frames of a programmed line count. When a trigger rises inside the allowed vertical window, a programmable countdown starts. When the countdown ends, the counters restart, so the output frame follows the input frame.

A fractional accumulator lengthens a chosen share of lines by one or two pixels. This lets the average line length land between whole-pixel values. A watchdog limit on the vertical count forces a restart when triggers stop, so the panel never freezes. A run control lets software stop the output cleanly at a frame boundary before the panel loses power.

Configuration is written through a simple write port with an address and a data word. The block drives the counters, the line and frame strobes, the current field parity and two status flags.

Top module: `frame_lock_seq`

## Requirements
- R1: Reset clears every configuration field to zero and leaves the sequencer halted. The counters read 0, shutdownReady is 1, vmaxSticky is 0 and fieldOdd is 0. Writes use these addresses:
  - 0: control. Bit 0 is run, bit 1 is interlace, bit 2 is extend-by-two, bit 3 is fixed-line lock, and bit 4 is a write-one pulse that clears the sticky flag.
  - 1: fraction [7:0].
  - 2: horizontal total.
  - 3: minimum vertical total.
  - 4: maximum vertical total.
  - 5: even-field delay.
  - 6: odd-field delay.
- R2: While running, hCount counts 0 up to the line length minus 1 and then wraps, and vCount steps at each wrap. lineStart is high when hCount is 0. frameStart is high when both counts are 0. With no trigger, a frame holds exactly maximum-vertical-total lines.
- R3: An 8-bit accumulator adds the fraction at every line start, with the first line after a run start unextended. A carry out lengthens that line by 1 pixel, or by 2 pixels when extend-by-two is set.
- R4: A trigger rising edge seen while vCount is below the minimum vertical total is ignored.
- R5: An accepted trigger rising edge loads the delay D. With fixed-line lock clear, the counters read 0/0 at the sample just after the (D+1)th clock edge following the edge that saw the trigger. This can cut the last line short.
- R6: With fixed-line lock set, an expired countdown waits until the current line ends before it resets the counters.
- R7: A trigger rising edge that arrives while a countdown is pending neither reloads nor restarts it.
- R8: With interlace clear the even delay is always used. With interlace set, fieldOdd toggles at each frame restart and the delay is taken from the current field. After a run start, fieldOdd is 0 and the even delay is used.
- R9: If the line that reaches the maximum vertical total ends with no reset due, the frame restarts and vmaxSticky is set. vmaxSticky stays 1 until a clear pulse is written.
- R10: Clearing run lets the current frame finish. The counters then hold at 0 and shutdownReady rises. Setting run again clears shutdownReady on the next clock and restarts counting from 0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWrData | input | DW (20) | Configuration write data |
| vertTrig | input | 1 | Vertical-enable trigger from the input side |
| hCount | output | HW+1 (13) | Horizontal pixel counter |
| vCount | output | VW (12) | Vertical line counter |
| lineStart | output | 1 | High on the first pixel of each line |
| frameStart | output | 1 | High on the first pixel of each frame |
| fieldOdd | output | 1 | Current field parity |
| vmaxSticky | output | 1 | Set by a forced restart at the maximum vertical total |
| shutdownReady | output | 1 | Sequencer halted at a frame boundary |

## Verification
The bench builds the block with its default widths: 12-bit totals, an 8-bit fraction and a 20-bit delay. It programs a 4-pixel line, a minimum of 3 lines and a maximum of 6. These short frames bring every line, trigger position and forced restart within a few dozen cycles. Delays of 0, 3 and 5 make the variable and fixed reset edges, the pending-trigger window and the even/odd delay alternation land on exact, hand-computable counter positions. Fractions of 0, 64, 128 and 255 give zero, one, two and four extended lines per frame in each extension mode.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FRAC   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_HTOT   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_VMIN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_VMAX   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_DLY_EV = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_DLY_OD = 3'd6;

  localparam int CB_RUN  = 0;
  localparam int CB_INTL = 1;
  localparam int CB_BY2  = 2;
  localparam int CB_FIX  = 3;
  localparam int CB_CLR  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic haltZero;      // hold counters and accumulator at zero
    logic frameRestart;  // restart the frame at the next edge
  } seqStrobe_t;
endpackage

// File: rtl/fls_ctrl.sv
module fls_ctrl
  import frame_lock_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int DW = 20,
  parameter int FW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DW-1:0]     cfgWrData,
  input  logic              vertTrig,
  input  logic [VW-1:0]     vCount,
  input  logic              lineLast,
  input  logic              forceEnd,
  output seqStrobe_t        st,
  output logic [HW-1:0]     hTotal,
  output logic [FW-1:0]     frac,
  output logic              extBy2,
  output logic [VW-1:0]     vMax,
  output logic              fieldOdd,
  output logic              vmaxSticky,
  output logic              shutdownReady
);
  logic          runBit, intlBit, fixBit;
  logic [VW-1:0] vMin;
  logic [DW-1:0] dlyEven, dlyOdd;
  logic          stickyClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      intlBit <= 1'b0;
      extBy2  <= 1'b0;
      fixBit  <= 1'b0;
      frac    <= '0;
      hTotal  <= '0;
      vMin    <= '0;
      vMax    <= '0;
      dlyEven <= '0;
      dlyOdd  <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        ADDR_CTRL: begin
          runBit  <= cfgWrData[CB_RUN];
          intlBit <= cfgWrData[CB_INTL];
          extBy2  <= cfgWrData[CB_BY2];
          fixBit  <= cfgWrData[CB_FIX];
        end
        ADDR_FRAC:   frac    <= cfgWrData[FW-1:0];
        ADDR_HTOT:   hTotal  <= cfgWrData[HW-1:0];
        ADDR_VMIN:   vMin    <= cfgWrData[VW-1:0];
        ADDR_VMAX:   vMax    <= cfgWrData[VW-1:0];
        ADDR_DLY_EV: dlyEven <= cfgWrData;
        ADDR_DLY_OD: dlyOdd  <= cfgWrData;
        default: ;
      endcase
    end
  end

  assign stickyClr = cfgWrEn && (cfgAddr == ADDR_CTRL) && cfgWrData[CB_CLR];

  // trigger edge, countdown and run state
  logic          trigPrev, trigEdge, accept;
  logic          pending, halted;
  logic [DW-1:0] delayCnt;
  logic          doReset, restart, forcedLive;

  assign trigEdge   = vertTrig && !trigPrev;
  assign accept     = trigEdge && !halted && !pending && (vCount >= vMin);
  assign doReset    = pending && (delayCnt == '0) && (!fixBit || lineLast);
  assign restart    = !halted && (doReset || forceEnd);
  assign forcedLive = !halted && forceEnd && !doReset;

  assign st.haltZero     = halted;
  assign st.frameRestart = restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev      <= 1'b0;
      pending       <= 1'b0;
      delayCnt      <= '0;
      halted        <= 1'b1;
      shutdownReady <= 1'b1;
      fieldOdd      <= 1'b0;
    end else begin
      trigPrev <= vertTrig;
      if (halted) begin
        pending  <= 1'b0;
        delayCnt <= '0;
        if (runBit) begin
          halted        <= 1'b0;
          shutdownReady <= 1'b0;
          fieldOdd      <= 1'b0;
        end
      end else if (restart) begin
        pending  <= 1'b0;
        fieldOdd <= intlBit ? !fieldOdd : 1'b0;
        if (!runBit) begin
          halted        <= 1'b1;
          shutdownReady <= 1'b1;
        end
      end else if (accept) begin
        pending  <= 1'b1;
        delayCnt <= (intlBit && fieldOdd) ? dlyOdd : dlyEven;
      end else if (pending && delayCnt != '0) begin
        delayCnt <= delayCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           vmaxSticky <= 1'b0;
    else if (forcedLive) vmaxSticky <= 1'b1;
    else if (stickyClr)  vmaxSticky <= 1'b0;
  end

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    forcedLive |=> vmaxSticky);
  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && delayCnt != '0 && !restart && !halted) |=>
      (pending && delayCnt == $past(delayCnt) - 1'b1));
  // R4
  early_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigEdge && vCount < vMin && !pending) |=> !pending);
  // R10
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !runBit) |=> (halted && shutdownReady));
endmodule

// File: rtl/fls_datapath.sv
module fls_datapath
  import frame_lock_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    st,
  input  logic [HW-1:0] hTotal,
  input  logic [FW-1:0] frac,
  input  logic          extBy2,
  input  logic [VW-1:0] vMax,
  output logic [HW:0]   hCount,
  output logic [VW-1:0] vCount,
  output logic          lineLast,
  output logic          forceEnd,
  output logic          lineStart,
  output logic          frameStart
);
  localparam int HCW = HW + 1;

  logic [FW-1:0]  acc;
  logic           extLine;
  logic [FW:0]    accSum;
  logic [HCW-1:0] extAmt, lineLen;
  logic [HCW:0]   hNext;
  logic [VW:0]    vNext;

  assign accSum   = {1'b0, acc} + {1'b0, frac};
  assign extAmt   = extLine ? (extBy2 ? HCW'(2) : HCW'(1)) : '0;
  assign lineLen  = {1'b0, hTotal} + extAmt;
  assign hNext    = {1'b0, hCount} + 1'b1;
  assign vNext    = {1'b0, vCount} + 1'b1;
  assign lineLast = hNext >= {1'b0, lineLen};
  assign forceEnd = lineLast && (vNext >= {1'b0, vMax});

  assign lineStart  = !st.haltZero && (hCount == '0);
  assign frameStart = lineStart && (vCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount  <= '0;
      vCount  <= '0;
      acc     <= '0;
      extLine <= 1'b0;
    end else if (st.haltZero) begin
      hCount  <= '0;
      vCount  <= '0;
      acc     <= '0;
      extLine <= 1'b0;
    end else if (st.frameRestart) begin
      hCount  <= '0;
      vCount  <= '0;
      acc     <= accSum[FW-1:0];
      extLine <= accSum[FW];
    end else if (lineLast) begin
      hCount  <= '0;
      vCount  <= vNext[VW-1:0];
      acc     <= accSum[FW-1:0];
      extLine <= accSum[FW];
    end else begin
      hCount  <= hNext[HCW-1:0];
    end
  end

  // R10
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.haltZero |=> (hCount == '0 && vCount == '0));
  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.frameRestart |=> (hCount == '0 && vCount == '0));
  // R2
  h_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.haltZero && !st.frameRestart && !lineLast) |=> (hCount == $past(hCount) + 1'b1));
endmodule

// File: rtl/frame_lock_seq.sv
module frame_lock_seq
  import frame_lock_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int DW = 20,
  parameter int FW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DW-1:0]     cfgWrData,
  input  logic              vertTrig,
  output logic [HW:0]       hCount,
  output logic [VW-1:0]     vCount,
  output logic              lineStart,
  output logic              frameStart,
  output logic              fieldOdd,
  output logic              vmaxSticky,
  output logic              shutdownReady
);
  seqStrobe_t    st;
  logic [HW-1:0] hTotal;
  logic [FW-1:0] frac;
  logic          extBy2;
  logic [VW-1:0] vMax;
  logic          lineLast, forceEnd;

  fls_ctrl #(.HW(HW), .VW(VW), .DW(DW), .FW(FW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .vertTrig(vertTrig), .vCount(vCount),
    .lineLast(lineLast), .forceEnd(forceEnd), .st(st), .hTotal(hTotal),
    .frac(frac), .extBy2(extBy2), .vMax(vMax), .fieldOdd(fieldOdd),
    .vmaxSticky(vmaxSticky), .shutdownReady(shutdownReady)
  );

  fls_datapath #(.HW(HW), .VW(VW), .FW(FW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .hTotal(hTotal), .frac(frac),
    .extBy2(extBy2), .vMax(vMax), .hCount(hCount), .vCount(vCount),
    .lineLast(lineLast), .forceEnd(forceEnd), .lineStart(lineStart),
    .frameStart(frameStart)
  );
endmodule

// File: tb/frame_lock_seq_tb.sv
module frame_lock_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 100000;
  localparam int C_RUN = 1, C_INTL = 2, C_BY2 = 4, C_FIX = 8, C_CLR = 16;

  localparam int ROWS = 6;
  localparam int FRAC_T [ROWS] = '{0, 128, 128, 255, 255, 64};
  localparam int BY2_T  [ROWS] = '{0, 0,   1,   0,   1,   1};
  localparam int LEN_T  [ROWS] = '{24, 26, 28,  28,  32,  26};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [19:0] cfgWrData = '0;
  logic        vertTrig = 1'b0;
  logic [12:0] hCount;
  logic [11:0] vCount;
  logic        lineStart, frameStart, fieldOdd, vmaxSticky, shutdownReady;

  int checks = 0, fails = 0, cycles = 0;

  frame_lock_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .vertTrig(vertTrig), .hCount(hCount),
    .vCount(vCount), .lineStart(lineStart), .frameStart(frameStart),
    .fieldOdd(fieldOdd), .vmaxSticky(vmaxSticky), .shutdownReady(shutdownReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog (R1..R10 run) actual=%0d expected<%0d", cycles, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    cfgWrEn = 1'b1; cfgAddr = 3'(addr); cfgWrData = 20'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitPos(input int h, input int v);
    while (!(hCount == 13'(h) && vCount == 12'(v) && !shutdownReady)) @(negedge clk);
  endtask

  task automatic waitFrame();
    while (!frameStart) @(negedge clk);
  endtask

  task automatic measureFrame(output int len, output int lines);
    waitFrame();
    len = 0; lines = 0;
    do begin
      if (lineStart) lines++;
      @(negedge clk);
      len++;
    end while (!frameStart);
  endtask

  task automatic haltWait();
    wr(0, 0);
    while (!shutdownReady) @(negedge clk);
  endtask

  task automatic pulseTrig();
    vertTrig = 1'b1;
    @(negedge clk);
    vertTrig = 1'b0;
  endtask

  initial begin
    int len, lines, lastH, lastV;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state: halted, counters zero, flags
    chk("R1 hCount", int'(hCount), 0);
    chk("R1 vCount", int'(vCount), 0);
    chk("R1 shutdownReady", int'(shutdownReady), 1);
    chk("R1 vmaxSticky", int'(vmaxSticky), 0);
    chk("R1 fieldOdd", int'(fieldOdd), 0);
    chk("R1 frameStart", int'(frameStart), 0);

    wr(2, 4); wr(3, 3); wr(4, 6);

    // R2 / R3 table walk: free-running frame length and line count
    for (int i = 0; i < ROWS; i++) begin
      wr(1, FRAC_T[i]);
      wr(0, C_RUN | (BY2_T[i] != 0 ? C_BY2 : 0));
      measureFrame(len, lines);
      chk($sformatf("R3 frame length row %0d", i), len, LEN_T[i]);
      chk($sformatf("R2 lines row %0d", i), lines, 6);
      haltWait();
    end

    wr(1, 0);
    wr(0, C_RUN);

    // R4: trigger below minimum is ignored, frame runs to max
    waitFrame();
    wr(0, C_RUN | C_CLR);
    waitPos(1, 1);
    pulseTrig();
    lastV = 0;
    while (!frameStart) begin lastV = int'(vCount); @(negedge clk); end
    chk("R4 last line before restart", lastV, 5);
    chk("R4 forced restart sticky", int'(vmaxSticky), 1);

    // R5: variable lock, delay 0, reset after E1
    waitFrame();
    wr(0, C_RUN | C_CLR);
    waitPos(1, 3);
    pulseTrig();
    @(negedge clk);
    chk("R5 hCount after reset", int'(hCount), 0);
    chk("R5 vCount after reset", int'(vCount), 0);
    chk("R5 frameStart", int'(frameStart), 1);
    chk("R5 no sticky", int'(vmaxSticky), 0);

    // R6: fixed lock waits for line end
    wr(0, C_RUN | C_FIX);
    waitFrame();
    waitPos(1, 3);
    pulseTrig();
    @(negedge clk);
    chk("R6 hCount still counting", int'(hCount), 3);
    chk("R6 vCount still counting", int'(vCount), 3);
    @(negedge clk);
    chk("R6 hCount at line end", int'(hCount), 0);
    chk("R6 vCount at line end", int'(vCount), 0);

    // R7: second trigger while pending ignored
    wr(5, 5);
    wr(0, C_RUN);
    waitFrame();
    waitPos(1, 3);
    vertTrig = 1'b1; @(negedge clk);
    vertTrig = 1'b0; @(negedge clk);
    vertTrig = 1'b1; @(negedge clk);
    vertTrig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 hCount before expiry", int'(hCount), 3);
    @(negedge clk);
    chk("R7 hCount at first delay", int'(hCount), 0);
    chk("R7 vCount at first delay", int'(vCount), 0);

    // R8: interlace alternates even (0) and odd (3) delays
    wr(5, 0); wr(6, 3);
    haltWait();
    wr(0, C_RUN | C_INTL);
    waitFrame();
    chk("R8 field after run start", int'(fieldOdd), 0);
    waitPos(1, 3);
    pulseTrig();
    @(negedge clk);
    chk("R8 even delay reset vCount", int'(vCount), 0);
    chk("R8 field toggled", int'(fieldOdd), 1);
    waitPos(1, 3);
    pulseTrig();
    repeat (3) @(negedge clk);
    chk("R8 odd delay not yet hCount", int'(hCount), 1);
    chk("R8 odd delay not yet vCount", int'(vCount), 4);
    @(negedge clk);
    chk("R8 odd delay reset hCount", int'(hCount), 0);
    chk("R8 odd delay reset vCount", int'(vCount), 0);
    chk("R8 field back to even", int'(fieldOdd), 0);

    // R9: sticky set by forced restart, held, cleared by pulse
    wr(0, C_RUN);
    waitFrame();
    wr(0, C_RUN | C_CLR);
    chk("R9 sticky cleared", int'(vmaxSticky), 0);
    measureFrame(len, lines);
    chk("R9 sticky set by forced restart", int'(vmaxSticky), 1);
    wr(6, 7);
    chk("R9 sticky held", int'(vmaxSticky), 1);
    wr(0, C_RUN | C_CLR);
    chk("R9 sticky cleared again", int'(vmaxSticky), 0);

    // R10: orderly stop and restart
    waitPos(0, 2);
    wr(0, 0);
    chk("R10 not ready mid frame", int'(shutdownReady), 0);
    lastH = 0; lastV = 0;
    while (!shutdownReady) begin
      lastH = int'(hCount); lastV = int'(vCount); @(negedge clk);
    end
    chk("R10 frame finished vCount", lastV, 5);
    chk("R10 frame finished hCount", lastH, 3);
    repeat (5) @(negedge clk);
    chk("R10 held hCount", int'(hCount), 0);
    chk("R10 held vCount", int'(vCount), 0);
    chk("R10 held ready", int'(shutdownReady), 1);
    wr(0, C_RUN);
    chk("R10 ready until next clock", int'(shutdownReady), 1);
    @(negedge clk);
    chk("R10 ready cleared", int'(shutdownReady), 0);
    chk("R10 restart frameStart", int'(frameStart), 1);
    @(negedge clk);
    chk("R10 counting resumes", int'(hCount), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule